// File: doc/BRIEF.md
# Descriptor Ring Ownership Manager

This block is the device-side bookkeeping engine for a pair of descriptor rings held in shared memory: one ring of transmit descriptors and one ring of receive descriptors. Each descriptor is 16 bytes long. The block reaches the descriptors through a simple 32-bit word memory port. A one-bit ownership flag in every descriptor decides which side may touch the entry, and only the side that currently owns the entry may pass it to the other side.

On the transmit side the engine polls the descriptor at its ring pointer. It polls on a fixed interval, and at once when a demand pulse arrives. If the device owns that descriptor, the engine reads the buffer address and byte count and raises a transmit request to the frame mover. When the frame mover signals completion, the engine gives the descriptor back to the host, pulses a done event and steps to the next entry.

On the receive side a frame-arrival pulse carries a length. If the device owns the current receive descriptor, the engine writes the length into it, hands the descriptor back and advances. If the host owns it, the frame is dropped and a missed-frame event is raised.

Top module: `desc_ring_mgr`

## Requirements
- R1: A descriptor at byte address A has four parts. The word at A+0 is the buffer address. In the word at A+4, bits 15:12 are all ones and bits 11:0 are the two's complement of the byte length, so the length equals (-bits[11:0]) mod 4096. Bit 31 of that word is the ownership flag (1 = device owns it). Bit 25 marks start of packet and bit 24 marks end of packet.
- R2: When a poll reads a device-owned transmit descriptor, tx_req rises. It carries the buffer address on tx_addr, the decoded length on tx_len and the start and end marks on tx_sop and tx_eop. It holds all of them unchanged until tx_cmpl.
- R3: After tx_cmpl the engine writes the word at A+4 back with bit 31 cleared and every other bit kept as read. It pulses tx_done in the same cycle as that write and advances the transmit pointer. tx_req is low by then.
- R4: A poll that finds a host-owned transmit descriptor raises no request, writes nothing and leaves the transmit pointer where it was.
- R5: While no transmit is outstanding, the transmit descriptor is polled once every POLL_CYCLES cycles. A tx_demand pulse starts a poll without waiting for the interval.
- R6: On rx_frame, if the current receive descriptor is device-owned, the engine writes the word at A+8 with bits 15:0 set to the plain length and bits 31:16 set to zero. It then writes A+4 with bit 31 cleared and the rest kept, pulses rx_done and advances the receive pointer.
- R7: On rx_frame with a host-owned receive descriptor, the engine pulses rx_miss, writes nothing, and keeps the receive pointer, so the next frame goes to the same descriptor.
- R8: Each ring holds 2^log2 entries (log2 at most 9). Descriptor i sits at base + 16*i, and the pointer wraps from the last entry back to entry 0.
- R9: The init pulse loads both ring bases and log2 lengths and sets both pointers to 0. Before the first init the block makes no memory access and raises no request.
- R10: A pending receive frame is served before a transmit poll that is due in the same cycle. Every memory access is word aligned, and read data is taken in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| init | input | 1 | Load ring configuration, zero pointers |
| tx_base | input | 32 | Byte address of transmit ring |
| rx_base | input | 32 | Byte address of receive ring |
| tx_log2 | input | 4 | log2 of transmit ring entries |
| rx_log2 | input | 4 | log2 of receive ring entries |
| tx_demand | input | 1 | Force an immediate transmit poll |
| tx_cmpl | input | 1 | Frame mover finished current transmit |
| rx_frame | input | 1 | A received frame is ready |
| rx_len | input | 12 | Length of the received frame |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after request |
| tx_req | output | 1 | Transmit buffer ready |
| tx_addr | output | 32 | Transmit buffer address |
| tx_len | output | 12 | Transmit length in bytes |
| tx_sop | output | 1 | Start-of-packet mark |
| tx_eop | output | 1 | End-of-packet mark |
| tx_done | output | 1 | Transmit descriptor returned to host |
| rx_done | output | 1 | Receive descriptor returned to host |
| rx_miss | output | 1 | Frame dropped, descriptor host-owned |

## Verification
The properties assume a few things about the environment. The memory answers every read on the next cycle and never stalls. tx_cmpl arrives only while tx_req is high. A new rx_frame never comes while the previous frame is still being written back. The log2 inputs stay within the legal range. The bench keeps to these limits: it waits for rx_done or rx_miss before it sends the next frame, it pulses completion only after it has seen the request, and it changes descriptor contents only at points where the engine is not reading them. The one case it sets up on purpose is a transmit poll and a receive frame falling due together, which tests the ordering.

// File: rtl/desc_ring_mgr.sv
module desc_ring_mgr #(
  parameter int POLL_CYCLES = 256,
  parameter int PTR_W       = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic [31:0] tx_base,
  input  logic [31:0] rx_base,
  input  logic [3:0]  tx_log2,
  input  logic [3:0]  rx_log2,
  input  logic        tx_demand,
  input  logic        tx_cmpl,
  input  logic        rx_frame,
  input  logic [11:0] rx_len,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        tx_req,
  output logic [31:0] tx_addr,
  output logic [11:0] tx_len,
  output logic        tx_sop,
  output logic        tx_eop,
  output logic        tx_done,
  output logic        rx_done,
  output logic        rx_miss
);
  localparam int TW = $clog2(POLL_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_TRD1, S_TCHK, S_TRD0, S_TGET, S_TWB,
    S_RRD1, S_RCHK, S_RLEN, S_RWB
  } st_t;

  st_t st;
  logic             armed, tx_active, wb_p, dmd_p, rx_p;
  logic [31:0]      txb, rxb, tw1, rw1, taddr_q;
  logic [3:0]       txl, rxl;
  logic [PTR_W-1:0] tptr, rptr;
  logic [11:0]      rlen_q;
  logic [TW-1:0]    timer;

  wire [PTR_W-1:0] tmask = PTR_W'((32'd1 << txl) - 32'd1);
  wire [PTR_W-1:0] rmask = PTR_W'((32'd1 << rxl) - 32'd1);
  wire [31:0] tdesc = txb + {{(28-PTR_W){1'b0}}, tptr, 4'b0000};
  wire [31:0] rdesc = rxb + {{(28-PTR_W){1'b0}}, rptr, 4'b0000};
  wire        poll_due = !tx_active && !wb_p && (dmd_p || timer == '0);

  assign tx_req  = tx_active;
  assign tx_addr = taddr_q;
  assign tx_len  = ~tw1[11:0] + 12'd1;
  assign tx_sop  = tw1[25];
  assign tx_eop  = tw1[24];
  assign tx_done = (st == S_TWB);
  assign rx_done = (st == S_RWB);
  assign rx_miss = (st == S_RCHK) && !mem_rdata[31];

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_TRD1: begin mem_req = 1'b1; mem_addr = tdesc + 32'd4; end
      S_TRD0: begin mem_req = 1'b1; mem_addr = tdesc; end
      S_TWB:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = tdesc + 32'd4;
                    mem_wdata = {1'b0, tw1[30:0]}; end
      S_RRD1: begin mem_req = 1'b1; mem_addr = rdesc + 32'd4; end
      S_RLEN: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = rdesc + 32'd8;
                    mem_wdata = {20'h0, rlen_q}; end
      S_RWB:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = rdesc + 32'd4;
                    mem_wdata = {1'b0, rw1[30:0]}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; armed <= 1'b0; tx_active <= 1'b0; wb_p <= 1'b0;
      dmd_p <= 1'b0; rx_p <= 1'b0; txb <= '0; rxb <= '0; tw1 <= '0;
      rw1 <= '0; taddr_q <= '0; txl <= '0; rxl <= '0; tptr <= '0;
      rptr <= '0; rlen_q <= '0; timer <= TW'(POLL_CYCLES);
    end else if (init) begin
      st <= S_IDLE; armed <= 1'b1; tx_active <= 1'b0; wb_p <= 1'b0;
      dmd_p <= 1'b0; rx_p <= 1'b0; txb <= tx_base; rxb <= rx_base;
      txl <= tx_log2; rxl <= rx_log2; tptr <= '0; rptr <= '0;
      timer <= TW'(POLL_CYCLES);
    end else begin
      if (armed && !tx_active && timer != '0) timer <= timer - 1'b1;
      case (st)
        S_IDLE: if (armed) begin
          if (rx_p) begin
            rx_p <= 1'b0; st <= S_RRD1;
          end else if (wb_p) begin
            st <= S_TWB;
          end else if (poll_due) begin
            dmd_p <= 1'b0; timer <= TW'(POLL_CYCLES); st <= S_TRD1;
          end
        end
        S_TRD1: st <= S_TCHK;
        S_TCHK: if (mem_rdata[31]) begin
          tw1 <= mem_rdata; st <= S_TRD0;
        end else st <= S_IDLE;
        S_TRD0: st <= S_TGET;
        S_TGET: begin taddr_q <= mem_rdata; tx_active <= 1'b1; st <= S_IDLE; end
        S_TWB:  begin tptr <= (tptr + 1'b1) & tmask; wb_p <= 1'b0; st <= S_IDLE; end
        S_RRD1: st <= S_RCHK;
        S_RCHK: if (mem_rdata[31]) begin
          rw1 <= mem_rdata; st <= S_RLEN;
        end else st <= S_IDLE;
        S_RLEN: st <= S_RWB;
        S_RWB:  begin rptr <= (rptr + 1'b1) & rmask; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
      if (tx_cmpl && tx_active) begin tx_active <= 1'b0; wb_p <= 1'b1; end
      if (tx_demand) dmd_p <= 1'b1;
      if (rx_frame) begin rx_p <= 1'b1; rlen_q <= rx_len; end
    end
  end
endmodule

// File: rtl/desc_ring_mgr_chk.sv
module desc_ring_mgr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        init,
  input logic        tx_cmpl,
  input logic        tx_req,
  input logic [31:0] tx_addr,
  input logic [11:0] tx_len,
  input logic        tx_done,
  input logic        rx_done,
  input logic        rx_miss,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_cmpl && !init |=> tx_req && $stable(tx_addr) && $stable(tx_len)); // R2
  AST_HANDBACK_CLEARS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done || rx_done) |-> mem_req && mem_we && !mem_wdata[31]); // R3
  AST_TX_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !tx_req); // R3
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_done, rx_done, rx_miss})); // R6
  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_miss |-> !(mem_req && mem_we)); // R7
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R10
endmodule

bind desc_ring_mgr desc_ring_mgr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .tx_cmpl(tx_cmpl), .tx_req(tx_req),
  .tx_addr(tx_addr), .tx_len(tx_len), .tx_done(tx_done), .rx_done(rx_done),
  .rx_miss(rx_miss), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/desc_ring_mgr_bench.sv
`timescale 1ns/1ps
module desc_ring_mgr_bench;
  localparam int POLL = 40;
  logic clk = 1'b0, rst_n, init, tx_demand, tx_cmpl, rx_frame;
  logic [31:0] tx_base, rx_base, mem_rdata;
  logic [3:0]  tx_log2, rx_log2;
  logic [11:0] rx_len;
  logic mem_req, mem_we, tx_req, tx_sop, tx_eop, tx_done, rx_done, rx_miss;
  logic [31:0] mem_addr, mem_wdata, tx_addr;
  logic [11:0] tx_len;
  logic [31:0] mem [0:255];
  int checks = 0, errors = 0, mtx = 0, mrx = 0;
  bit finished = 0;

  desc_ring_mgr #(.POLL_CYCLES(POLL)) u_desc_ring_mgr (
    .clk(clk), .rst_n(rst_n), .init(init), .tx_base(tx_base), .rx_base(rx_base),
    .tx_log2(tx_log2), .rx_log2(rx_log2), .tx_demand(tx_demand), .tx_cmpl(tx_cmpl),
    .rx_frame(rx_frame), .rx_len(rx_len), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_req(tx_req), .tx_addr(tx_addr), .tx_len(tx_len), .tx_sop(tx_sop),
    .tx_eop(tx_eop), .tx_done(tx_done), .rx_done(rx_done), .rx_miss(rx_miss));

  always #2 clk = ~clk;

  always @(posedge clk)
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // reference ring pointers, compared against every memory write
  always @(negedge clk) if (rst_n) begin
    if (mem_req && mem_we) begin
      logic [31:0] ta, ra;
      ta = tx_base + 32'(16 * mtx);
      ra = rx_base + 32'(16 * mrx);
      chk(mem_addr == ta + 4 || mem_addr == ra + 4 || mem_addr == ra + 8,
          "R8 write address", mem_addr, ra + 4);
    end
    if (tx_done) mtx = (mtx + 1) % (1 << tx_log2);
    if (rx_done) mrx = (mrx + 1) % (1 << rx_log2);
    if (init) begin mtx = 0; mrx = 0; end
  end

  function automatic logic [31:0] txw1(input bit own, input int len);
    return {own, 5'b0, 2'b11, 8'h5A, 4'hF, 12'(-len)};
  endfunction
  function automatic logic [31:0] rxw1(input bit own);
    return {own, 7'b0, 8'h3C, 4'hF, 12'(-1520)};
  endfunction

  task automatic step(); @(posedge clk); #1; endtask
  task automatic set_tx(input int i, input logic [31:0] a, input int len, input bit own);
    mem[i*4] = a; mem[i*4+1] = txw1(own, len);
  endtask
  task automatic set_rx(input int i, input bit own);
    mem[128+i*4] = 32'h8000 + 32'(i); mem[128+i*4+1] = rxw1(own); mem[128+i*4+2] = 32'hFFFF_FFFF;
  endtask
  task automatic demand(); step(); tx_demand = 1; step(); tx_demand = 0; endtask
  task automatic cmpl();   step(); tx_cmpl = 1;   step(); tx_cmpl = 0;   endtask
  task automatic frame(input int len); step(); rx_frame = 1; rx_len = 12'(len); step(); rx_frame = 0; endtask
  task automatic do_init();
    step(); tx_base = 0; rx_base = 32'h200; tx_log2 = 1; rx_log2 = 1; init = 1; step(); init = 0;
  endtask
  // which: 0 tx_req, 1 tx_done, 2 rx_done, 3 rx_miss
  task automatic wait_evt(input int which, input int maxc, output bit seen);
    seen = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      case (which)
        0: seen = tx_req; 1: seen = tx_done; 2: seen = rx_done; default: seen = rx_miss;
      endcase
      if (seen) break;
    end
  endtask
  task automatic tx_round(input string r, input logic [31:0] a, input int len);
    bit s;
    wait_evt(0, POLL + 20, s);
    chk(s, {r, " tx_req"}, 32'(s), 1);
    chk(tx_addr == a, {r, " tx_addr"}, tx_addr, a);
    chk(tx_len == 12'(len), {r, " tx_len"}, 32'(tx_len), 32'(len));
    cmpl();
    wait_evt(1, 10, s);
    chk(s, {r, " tx_done"}, 32'(s), 1);
  endtask

  initial begin
    bit s, early;
    logic [31:0] w1, w2;
    rst_n = 0; init = 0; tx_demand = 0; tx_cmpl = 0; rx_frame = 0; rx_len = 0;
    tx_base = 0; rx_base = 0; tx_log2 = 0; rx_log2 = 0; mem_rdata = 0;
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) step();
    rst_n = 1;
    // R9: idle before first init
    early = 0;
    for (int i = 0; i < 2 * POLL; i++) begin @(negedge clk); if (mem_req || tx_req) early = 1; end
    chk(!early, "R9 no activity before init", 32'(early), 0);
    do_init();

    // R1 R2 R3 R5: demand-driven transmit
    set_tx(0, 32'h1000, 60, 1);
    demand();
    wait_evt(0, 10, s);
    chk(s, "R5 demand poll", 32'(s), 1);
    chk(tx_addr == 32'h1000, "R2 tx_addr", tx_addr, 32'h1000);
    chk(tx_len == 12'd60, "R1 tx_len decode", 32'(tx_len), 60);
    chk(tx_sop && tx_eop, "R1 sop/eop", {tx_sop, tx_eop}, 2'b11);
    repeat (5) @(negedge clk);
    chk(tx_req && tx_addr == 32'h1000, "R2 request held", 32'(tx_req), 1);
    cmpl();
    wait_evt(1, 10, s);
    chk(s, "R3 tx_done", 32'(s), 1);
    @(negedge clk);
    chk(!tx_req, "R3 tx_req dropped", 32'(tx_req), 0);
    chk(mem[1] == txw1(0, 60), "R3 ownership cleared, rest kept", mem[1], txw1(0, 60));

    // R4: host-owned descriptor
    set_tx(1, 32'h2000, 1518, 0);
    demand();
    early = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (tx_req) early = 1; end
    chk(!early, "R4 no request on host-owned", 32'(early), 0);
    chk(mem[5] == txw1(0, 1518), "R4 descriptor untouched", mem[5], txw1(0, 1518));
    // R5 periodic poll, R4 pointer unchanged, R1 long length
    set_tx(1, 32'h2000, 1518, 1);
    tx_round("R5 periodic poll", 32'h2000, 1518);
    // R8 wrap to entry 0, R1 minimum length
    set_tx(0, 32'h3000, 1, 1);
    demand();
    tx_round("R8 tx wrap", 32'h3000, 1);

    // R6 receive
    set_rx(0, 1);
    frame(100);
    wait_evt(2, 20, s);
    chk(s, "R6 rx_done", 32'(s), 1);
    @(negedge clk);
    chk(mem[130] == 32'd100, "R6 length word", mem[130], 100);
    chk(mem[129] == rxw1(0), "R6 ownership cleared, rest kept", mem[129], rxw1(0));

    // R7 miss
    set_rx(1, 0);
    w1 = mem[133]; w2 = mem[134];
    frame(200);
    wait_evt(3, 20, s);
    chk(s, "R7 rx_miss", 32'(s), 1);
    repeat (3) @(negedge clk);
    chk(mem[133] == w1 && mem[134] == w2, "R7 descriptor untouched", mem[134], w2);
    mem[133] = rxw1(1);
    frame(300);
    wait_evt(2, 20, s);
    chk(s, "R7 next frame rx_done", 32'(s), 1);
    @(negedge clk);
    chk(mem[134] == 32'd300, "R7 pointer held", mem[134], 300);

    // R8 receive wrap
    set_rx(0, 1);
    frame(64);
    wait_evt(2, 20, s);
    @(negedge clk);
    chk(s && mem[130] == 32'd64, "R8 rx wrap", mem[130], 64);

    // R10 receive before transmit poll
    set_tx(1, 32'h4000, 500, 0);
    set_rx(1, 1);
    s = 0;
    for (int i = 0; i < 3 * POLL; i++) begin
      @(negedge clk);
      if (mem_req && !mem_we && mem_addr == 32'h14) begin s = 1; break; end
    end
    chk(s, "R10 poll observed", 32'(s), 1);
    step();
    mem[5] = txw1(1, 500); rx_frame = 1; rx_len = 12'd77; tx_demand = 1;
    step();
    rx_frame = 0; tx_demand = 0;
    s = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mem_req) begin s = 1; break; end
    end
    chk(s && mem_addr == 32'h214, "R10 rx served first", mem_addr, 32'h214);
    wait_evt(2, 20, s);
    chk(s, "R10 rx_done", 32'(s), 1);
    tx_round("R10 tx after rx", 32'h4000, 500);

    // R9 init returns pointers to 0
    set_tx(0, 32'h5000, 90, 1);
    demand();
    tx_round("R9 pre-init tx", 32'h5000, 90);
    do_init();
    set_tx(0, 32'h6000, 128, 1);
    demand();
    tx_round("R9 tx pointer zeroed", 32'h6000, 128);
    set_rx(0, 1);
    set_rx(1, 1);
    frame(42);
    wait_evt(2, 20, s);
    @(negedge clk);
    chk(s && mem[130] == 32'd42, "R9 rx pointer zeroed", mem[130], 42);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule